// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block programs a run of 32-bit words into a flash device that has an on-chip write buffer. Each 32-bit bus access reaches two 16-bit flash devices side by side, so every command is sent with the same 16-bit value in both halves. Status is ready only when both halves report it. The requester first loads the words into a small internal array through a fill port. It then pulses a start input with the absolute word offset of the target, the word count, the word address of the erase block base, and the write-buffer size in bytes.

The sequencer cuts the run into chunks so that no chunk crosses a write-buffer boundary. The first chunk runs up to the next boundary, and every later chunk fills a whole buffer. For each chunk it asks for buffer mode, retrying until the device grants it. It then sends the word count minus one, the data words and a confirm command, and polls status until programming ends. A millisecond tick bounds both waits. An error bit or a timeout stops the run early.

Every run ends with a status-clear command and a device reset. A one-cycle done pulse follows, and the error flag and the last captured status word stay on the outputs until the next start.

Top module: `wbProgSeq`

## Requirements
- R1: After reset, done, errFlag, memReq and progPower are low and statusWord is zero.
- R2: Let B be the buffer size in words. The first chunk holds B minus (wordOffset mod B) words, every later chunk holds B words, and each chunk is clamped to the words still remaining. No chunk crosses a boundary of B words.
- R3: Each chunk begins by writing 0x00E800E8 to blockBase and then reading blockBase. The write and read pair repeats until the read value has bit 7 and bit 23 both set. A read with only one of the two bits set counts as not granted.
- R4: Once buffer mode is granted, the sequencer writes the chunk length minus one to blockBase in both 16-bit halves. It then writes the data words to consecutive word addresses starting at the current target address, taking array entries in run order. Last, it writes 0x00D000D0 to blockBase.
- R5: After the confirm command, the sequencer reads blockBase until bit 7 and bit 23 are both set. The last value read is captured on statusWord.
- R6: If the final status of a chunk has any of bits 1, 3, 4, 5, 17, 19, 20 or 21 set, the sequencer issues no further chunks and raises errFlag.
- R7: If buffer mode is not granted within TIMEOUT_MS ticks of msTick, the sequencer writes 0x00700070 to blockBase and reads blockBase once. It captures that value on statusWord, raises errFlag, and writes neither a count nor data.
- R8: If programming status is not ready within TIMEOUT_MS ticks after the confirm, the sequencer raises errFlag, keeps the last status read on statusWord, and issues no further chunks.
- R9: Every run ends by writing 0x00500050 to word address 0x100 and then 0x00FF00FF to word address 0x55. One cycle later done is high for exactly one cycle.
- R10: progPower is high during every bus access of a run and low once the run has finished.
- R11: A start with wordCount zero produces only the two finishing writes, with errFlag low and statusWord zero.
- R12: A start pulse while a run is in progress is ignored. The bus traffic of the run in progress is unchanged.
- R13: The buffer size in words is bufBytes divided by four, and bufBytes is a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| wordOffset | input | ADDR_W | Absolute word address of the first target word |
| wordCount | input | clog2(MAX_WORDS+1) | Number of words in the run |
| blockBase | input | ADDR_W | Word address of the erase block base |
| bufBytes | input | BUF_W | Write-buffer size in bytes (power of two) |
| fillWe | input | 1 | Write enable for the word array |
| fillIdx | input | clog2(MAX_WORDS) | Word array index |
| fillData | input | 32 | Word array write data |
| msTick | input | 1 | One-cycle pulse each millisecond |
| memReq | output | 1 | Bus request, held until memAck |
| memWe | output | 1 | Bus write (1) or read (0) |
| memAddr | output | ADDR_W | Bus word address |
| memWdata | output | 32 | Bus write data |
| memRdata | input | 32 | Bus read data, valid with memAck |
| memAck | input | 1 | Bus access complete |
| progPower | output | 1 | Programming power enable |
| done | output | 1 | One-cycle run-complete pulse |
| errFlag | output | 1 | Last run ended in error |
| statusWord | output | 32 | Last captured status value |

## Verification
The hardest behaviour to reach from the ports is the alignment arithmetic. The first-chunk length depends jointly on offset, remaining count and buffer size. The bench sweeps every offset within the largest buffer, counts from zero to beyond two buffers, and three buffer sizes. It compares the complete logged write stream with a sequence rebuilt arithmetically. The flash model answers with one-half-ready values so that both-halves gating is exercised. It can withhold buffer grants or completion forever to drive each timeout, and it can inject error status on a chosen chunk to show that the run stops there.

// File: rtl/wbProgPkg.sv
package wbProgPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_REQW, S_REQR, S_CNTW, S_DATW, S_CONFW,
    S_POLLR, S_TOW, S_TOR, S_CLRW, S_RSTW, S_DONE
  } seqStateT;

  typedef enum logic [2:0] {
    OP_BUFREQ, OP_STATRD, OP_COUNT, OP_DATA,
    OP_CONFIRM, OP_STATCMD, OP_CLEAR, OP_RESET
  } busOpT;

  typedef struct packed {
    logic loadRun;
    logic loadChunk;
    logic advWord;
    logic clrTimer;
    logic capStatus;
    logic setErr;
  } ctrlStrobeT;

  localparam logic [15:0] CMD_BUFREQ  = 16'h00E8;
  localparam logic [15:0] CMD_CONFIRM = 16'h00D0;
  localparam logic [15:0] CMD_READSR  = 16'h0070;
  localparam logic [15:0] CMD_CLEARSR = 16'h0050;
  localparam logic [15:0] CMD_RESET   = 16'h00FF;
  localparam logic [15:0] SR_ERRMASK  = 16'h003A;
  localparam int CLEAR_INDEX = 'h100;
  localparam int RESET_INDEX = 'h55;

  function automatic logic [31:0] mirror16(input logic [15:0] v);
    return {v, v};
  endfunction

endpackage

// File: rtl/wbProgPath.sv
module wbProgPath
  import wbProgPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MAX_WORDS  = 16,
  parameter int BUF_W      = 16,
  parameter int TIMEOUT_MS = 2000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobeT                     strobe,
  input  busOpT                          busOp,
  input  logic [ADDR_W-1:0]              wordOffset,
  input  logic [$clog2(MAX_WORDS+1)-1:0] wordCount,
  input  logic [ADDR_W-1:0]              blockBase,
  input  logic [BUF_W-1:0]               bufBytes,
  input  logic                           fillWe,
  input  logic [$clog2(MAX_WORDS)-1:0]   fillIdx,
  input  logic [31:0]                    fillData,
  input  logic                           msTick,
  input  logic [31:0]                    memRdata,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [31:0]                    memWdata,
  output logic                           readyBoth,
  output logic                           errAny,
  output logic                           timedOut,
  output logic                           chunkLast,
  output logic                           runEmpty,
  output logic [31:0]                    statusWord,
  output logic                           errFlag
);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int TMR_W = $clog2(TIMEOUT_MS + 1);

  logic [31:0]       wordMem [MAX_WORDS];
  logic [ADDR_W-1:0] offReg, baseReg;
  logic [CNT_W-1:0]  remReg, chunkLen, chunkCnt, nextLen;
  logic [IDX_W-1:0]  idxReg;
  logic [BUF_W-1:0]  bufWordsReg, bufMask, offPhase, room, remWide;
  logic [TMR_W-1:0]  msCount;

  always_ff @(posedge clk) begin
    if (fillWe) wordMem[fillIdx] <= fillData;
  end

  // chunk sizing: distance to the next buffer boundary, clamped to what is left
  always_comb begin
    bufMask  = bufWordsReg - 1'b1;
    offPhase = offReg[BUF_W-1:0] & bufMask;
    room     = bufWordsReg - offPhase;
    remWide  = BUF_W'(remReg);
    nextLen  = (room < remWide) ? CNT_W'(room) : remReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg      <= '0;
      baseReg     <= '0;
      remReg      <= '0;
      chunkLen    <= '0;
      chunkCnt    <= '0;
      idxReg      <= '0;
      bufWordsReg <= '0;
      statusWord  <= '0;
      errFlag     <= 1'b0;
    end else begin
      if (strobe.loadRun) begin
        offReg      <= wordOffset;
        baseReg     <= blockBase;
        remReg      <= wordCount;
        idxReg      <= '0;
        bufWordsReg <= bufBytes >> 2;
        statusWord  <= '0;
        errFlag     <= 1'b0;
      end
      if (strobe.loadChunk) begin
        chunkLen <= nextLen;
        chunkCnt <= nextLen;
      end
      if (strobe.advWord) begin
        offReg   <= offReg + 1'b1;
        idxReg   <= idxReg + 1'b1;
        remReg   <= remReg - 1'b1;
        chunkCnt <= chunkCnt - 1'b1;
      end
      if (strobe.capStatus) statusWord <= memRdata;
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) msCount <= '0;
    else if (msTick && (msCount < TMR_W'(TIMEOUT_MS))) msCount <= msCount + 1'b1;
  end

  assign timedOut  = (msCount >= TMR_W'(TIMEOUT_MS));
  assign chunkLast = (chunkCnt == CNT_W'(1));
  assign runEmpty  = (remReg == '0);
  assign readyBoth = memRdata[7] && memRdata[23];
  assign errAny    = |(memRdata & mirror16(SR_ERRMASK));

  always_comb begin
    memAddr  = baseReg;
    memWdata = '0;
    case (busOp)
      OP_BUFREQ:  memWdata = mirror16(CMD_BUFREQ);
      OP_COUNT:   memWdata = mirror16(16'(chunkLen) - 16'd1);
      OP_DATA: begin
        memAddr  = offReg;
        memWdata = wordMem[idxReg];
      end
      OP_CONFIRM: memWdata = mirror16(CMD_CONFIRM);
      OP_STATCMD: memWdata = mirror16(CMD_READSR);
      OP_CLEAR: begin
        memAddr  = ADDR_W'(CLEAR_INDEX);
        memWdata = mirror16(CMD_CLEARSR);
      end
      OP_RESET: begin
        memAddr  = ADDR_W'(RESET_INDEX);
        memWdata = mirror16(CMD_RESET);
      end
      default: memWdata = '0;
    endcase
  end

  AST_CHUNK_IN_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadChunk |=> (({1'b0, offPhase} + (BUF_W+1)'(chunkCnt)) <= {1'b0, bufWordsReg})); // R2
  AST_WORD_IN_CHUNK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advWord |-> (chunkCnt != '0) && (remReg != '0)); // R4
  AST_TIMER_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    msCount <= TMR_W'(TIMEOUT_MS)); // R7

endmodule

// File: rtl/wbProgCtrl.sv
module wbProgCtrl
  import wbProgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       memAck,
  input  logic       readyBoth,
  input  logic       errAny,
  input  logic       timedOut,
  input  logic       chunkLast,
  input  logic       runEmpty,
  output ctrlStrobeT strobe,
  output busOpT      busOp,
  output logic       memReq,
  output logic       memWe,
  output logic       done,
  output logic       progPower
);
  seqStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    busOp     = OP_STATRD;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      S_IDLE: if (startReq) begin
        strobe.loadRun = 1'b1;
        nextState      = S_PLAN;
      end
      S_PLAN: begin
        if (runEmpty) nextState = S_CLRW;
        else begin
          strobe.loadChunk = 1'b1;
          strobe.clrTimer  = 1'b1;
          nextState        = S_REQW;
        end
      end
      S_REQW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_BUFREQ;
        if (memAck) nextState = S_REQR;
      end
      S_REQR: begin
        memReq = 1'b1;
        if (memAck) begin
          if (readyBoth)     nextState = S_CNTW;
          else if (timedOut) nextState = S_TOW;
          else               nextState = S_REQW;
        end
      end
      S_CNTW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_COUNT;
        if (memAck) nextState = S_DATW;
      end
      S_DATW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_DATA;
        if (memAck) begin
          strobe.advWord = 1'b1;
          if (chunkLast) nextState = S_CONFW;
        end
      end
      S_CONFW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_CONFIRM;
        if (memAck) begin
          strobe.clrTimer = 1'b1;
          nextState       = S_POLLR;
        end
      end
      S_POLLR: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capStatus = 1'b1;
          if (readyBoth) begin
            if (errAny) begin
              strobe.setErr = 1'b1;
              nextState     = S_CLRW;
            end else nextState = S_PLAN;
          end else if (timedOut) begin
            strobe.setErr = 1'b1;
            nextState     = S_CLRW;
          end
        end
      end
      S_TOW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_STATCMD;
        if (memAck) nextState = S_TOR;
      end
      S_TOR: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capStatus = 1'b1;
          strobe.setErr    = 1'b1;
          nextState        = S_CLRW;
        end
      end
      S_CLRW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_CLEAR;
        if (memAck) nextState = S_RSTW;
      end
      S_RSTW: begin
        memReq = 1'b1; memWe = 1'b1; busOp = OP_RESET;
        if (memAck) nextState = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign done      = (state == S_DONE);
  assign progPower = (state != S_IDLE) && (state != S_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_POWER_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> progPower); // R10
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (progPower && startReq) |=> !strobe.loadRun); // R12

endmodule

// File: rtl/wbProgSeq.sv
module wbProgSeq
  import wbProgPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MAX_WORDS  = 16,
  parameter int BUF_W      = 16,
  parameter int TIMEOUT_MS = 2000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startReq,
  input  logic [ADDR_W-1:0]              wordOffset,
  input  logic [$clog2(MAX_WORDS+1)-1:0] wordCount,
  input  logic [ADDR_W-1:0]              blockBase,
  input  logic [BUF_W-1:0]               bufBytes,
  input  logic                           fillWe,
  input  logic [$clog2(MAX_WORDS)-1:0]   fillIdx,
  input  logic [31:0]                    fillData,
  input  logic                           msTick,
  output logic                           memReq,
  output logic                           memWe,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [31:0]                    memWdata,
  input  logic [31:0]                    memRdata,
  input  logic                           memAck,
  output logic                           progPower,
  output logic                           done,
  output logic                           errFlag,
  output logic [31:0]                    statusWord
);
  ctrlStrobeT strobe;
  busOpT      busOp;
  logic readyBoth, errAny, timedOut, chunkLast, runEmpty;

  wbProgCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memAck(memAck),
    .readyBoth(readyBoth), .errAny(errAny), .timedOut(timedOut),
    .chunkLast(chunkLast), .runEmpty(runEmpty), .strobe(strobe),
    .busOp(busOp), .memReq(memReq), .memWe(memWe), .done(done),
    .progPower(progPower)
  );

  wbProgPath #(
    .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .BUF_W(BUF_W), .TIMEOUT_MS(TIMEOUT_MS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busOp(busOp),
    .wordOffset(wordOffset), .wordCount(wordCount), .blockBase(blockBase),
    .bufBytes(bufBytes), .fillWe(fillWe), .fillIdx(fillIdx), .fillData(fillData),
    .msTick(msTick), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .readyBoth(readyBoth), .errAny(errAny), .timedOut(timedOut),
    .chunkLast(chunkLast), .runEmpty(runEmpty), .statusWord(statusWord),
    .errFlag(errFlag)
  );

  AST_STATUS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!progPower && !startReq && !done) |=> $stable(statusWord) && $stable(errFlag)); // R5

endmodule

// File: tb/wbProgSeq_test.sv
module wbProgSeq_test;
  localparam int ADDR_W = 24;
  localparam int MAXW   = 16;
  localparam int BUF_W  = 16;
  localparam int TMO    = 20;
  localparam int CNT_W  = $clog2(MAXW + 1);
  localparam int IDX_W  = $clog2(MAXW);
  localparam logic [ADDR_W-1:0] BASE = 24'h000400;
  localparam int LOGMAX = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ADDR_W-1:0] wordOffset = '0;
  logic [CNT_W-1:0] wordCount = '0;
  logic [ADDR_W-1:0] blockBase = BASE;
  logic [BUF_W-1:0] bufBytes = 16'd16;
  logic fillWe = 1'b0;
  logic [IDX_W-1:0] fillIdx = '0;
  logic [31:0] fillData = '0;
  logic msTick = 1'b0;
  logic memReq, memWe, progPower, done, errFlag;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata, statusWord;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;

  always #2 clk = ~clk;

  wbProgSeq #(.ADDR_W(ADDR_W), .MAX_WORDS(MAXW), .BUF_W(BUF_W), .TIMEOUT_MS(TMO)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordOffset(wordOffset),
    .wordCount(wordCount), .blockBase(blockBase), .bufBytes(bufBytes),
    .fillWe(fillWe), .fillIdx(fillIdx), .fillData(fillData), .msTick(msTick),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .progPower(progPower), .done(done),
    .errFlag(errFlag), .statusWord(statusWord)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // flash model state
  int logN, mode, reqCnt, pollCnt, d0Count, curChunk;
  int reqFails, pollBusy, errChunk;
  logic [31:0] errStat;
  bit powerBad;
  logic [ADDR_W-1:0] logA [LOGMAX];
  logic [31:0] logD [LOGMAX];
  logic [ADDR_W-1:0] expA [LOGMAX];
  logic [31:0] expD [LOGMAX];
  int expN;
  int tickDiv = 0;

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    msTick <= (tickDiv == 0);
  end

  always @(negedge clk) begin
    if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      memAck <= 1'b1;
      if (memWe) begin
        if (logN < LOGMAX) begin
          logA[logN] = memAddr;
          logD[logN] = memWdata;
        end
        logN = logN + 1;
        if (!progPower) powerBad = 1'b1;
        if (memAddr == BASE) begin
          if (memWdata == 32'h00E800E8) mode = 1;
          else if (memWdata == 32'h00D000D0) begin
            mode = 2; pollCnt = 0; reqCnt = 0;
            curChunk = d0Count; d0Count = d0Count + 1;
          end else if (memWdata == 32'h00700070) mode = 3;
        end
      end else begin
        case (mode)
          1: if (reqCnt < reqFails) begin
               memRdata <= 32'h00000080; reqCnt = reqCnt + 1;
             end else memRdata <= 32'h00800080;
          2: if (pollCnt < pollBusy) begin
               memRdata <= 32'h00800000; pollCnt = pollCnt + 1;
             end else memRdata <= (curChunk == errChunk) ? errStat : 32'h00800080;
          3: memRdata <= 32'h00120092;
          default: memRdata <= 32'h0;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] dataOf(input int seed, input int i);
    return 32'hC0DE0000 ^ 32'(seed << 8) ^ 32'(i);
  endfunction

  task automatic push(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    expA[expN] = a; expD[expN] = d; expN = expN + 1;
  endtask

  // expected write stream, built from R2 R3 R4 R9 R13
  task automatic buildExp(input int off, input int cnt, input int bufB, input int fails, input int stopChunk);
    int rem, o, idx, ch, bw, len;
    bw = bufB / 4; rem = cnt; o = off; idx = 0; ch = 0; expN = 0;
    while (rem > 0) begin
      len = bw - (o % bw);
      if (len > rem) len = rem;
      for (int k = 0; k <= fails; k++) push(BASE, 32'h00E800E8);
      push(BASE, {16'(len - 1), 16'(len - 1)});
      for (int i = 0; i < len; i++) push(BASE + ADDR_W'(o + i), dataOf(cnt + off, idx + i));
      push(BASE, 32'h00D000D0);
      o = o + len; idx = idx + len; rem = rem - len;
      if (ch == stopChunk) break;
      ch = ch + 1;
    end
    push(ADDR_W'(32'h100), 32'h00500050);
    push(ADDR_W'(32'h55), 32'h00FF00FF);
  endtask

  task automatic launch(input int off, input int cnt, input int bufB, input int fails,
                        input int busy, input int errCh, input logic [31:0] errS, input bit midStart);
    int n;
    for (int i = 0; i < MAXW; i++) begin
      @(negedge clk);
      fillWe = 1'b1; fillIdx = IDX_W'(i); fillData = dataOf(cnt + off, i);
    end
    @(negedge clk);
    fillWe = 1'b0;
    logN = 0; mode = 0; reqCnt = 0; pollCnt = 0; d0Count = 0; curChunk = -1; powerBad = 1'b0;
    reqFails = fails; pollBusy = busy; errChunk = errCh; errStat = errS;
    wordOffset = BASE + ADDR_W'(off); wordCount = CNT_W'(cnt); bufBytes = BUF_W'(bufB);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (midStart) begin
      repeat (6) @(negedge clk);
      wordOffset = BASE + 24'd3; wordCount = CNT_W'(1); bufBytes = 16'd8;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n = n + 1;
    end
    check(done, "R9 done pulse reached", 32'(done), 32'h1);
  endtask

  task automatic afterDone(input string tag);
    @(negedge clk);
    check(!done && !progPower, {tag, " R9 R10 done one cycle and power off"},
          {30'h0, done, progPower}, 32'h0);
    check(!powerBad, {tag, " R10 power high on each write"}, 32'(powerBad), 32'h0);
  endtask

  task automatic compareLog(input string tag);
    bit ok;
    int bad;
    ok = (logN == expN);
    bad = -1;
    if (ok) begin
      for (int i = 0; i < expN; i++)
        if (bad < 0 && (logA[i] != expA[i] || logD[i] != expD[i])) bad = i;
      ok = (bad < 0);
    end
    if (bad >= 0)
      check(ok, {tag, " write stream entry"}, logD[bad] ^ 32'(logA[bad]), expD[bad] ^ 32'(expA[bad]));
    else
      check(ok, {tag, " write stream length"}, 32'(logN), 32'(expN));
  endtask

  task automatic runJob(input int off, input int cnt, input int bufB, input int fails, input int busy,
                        input int errCh, input logic [31:0] errS, input bit midStart,
                        input bit expErr, input logic [31:0] expStat, input string tag);
    launch(off, cnt, bufB, fails, busy, errCh, errS, midStart);
    check(errFlag == expErr, {tag, " R6 R8 error flag"}, 32'(errFlag), 32'(expErr));
    check(statusWord == expStat, {tag, " R5 status word"}, statusWord, expStat);
    buildExp(off, cnt, bufB, fails, expErr ? errCh : -1);
    compareLog(tag);
    afterDone(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !errFlag && !memReq && !progPower && statusWord == 0, "R1 reset state",
          {statusWord[27:0], done, errFlag, memReq, progPower}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R11 zero-length run
    runJob(2, 0, 16, 0, 0, -1, 32'h0, 1'b0, 1'b0, 32'h0, "R11 zero count");

    // R2 R3 R4 R13 sweep of buffer size, offset and count
    for (int b = 3; b <= 5; b++)
      for (int off = 0; off < 8; off++)
        for (int cnt = 1; cnt <= 10; cnt++)
          runJob(off, cnt, 1 << b, (off + cnt) % 3, cnt % 3, -1, 32'h0, 1'b0,
                 1'b0, 32'h00800080, "R2 R3 R4 R13 sweep");

    // R6 error on the second chunk, upper half bit 20
    runJob(1, 10, 16, 1, 1, 1, 32'h00900080, 1'b0, 1'b1, 32'h00900080, "R6 upper error");
    // R6 error on the first chunk, lower half bit 1
    runJob(0, 9, 8, 0, 2, 0, 32'h00800082, 1'b0, 1'b1, 32'h00800082, "R6 lower error");
    // R8 programming never completes
    runJob(3, 8, 16, 0, 100000, 0, 32'h0, 1'b0, 1'b1, 32'h00800000, "R8 poll timeout");
    // R12 start ignored mid-run
    runJob(1, 12, 16, 2, 1, -1, 32'h0, 1'b1, 1'b0, 32'h00800080, "R12 mid-run start");

    // R7 buffer mode never granted
    launch(1, 5, 16, 100000, 0, -1, 32'h0, 1'b0);
    check(errFlag, "R7 error flag", 32'(errFlag), 32'h1);
    check(statusWord == 32'h00120092, "R7 status after read-status command", statusWord, 32'h00120092);
    begin
      bit ok;
      ok = (logN >= 5) && (logN <= LOGMAX);
      if (ok) begin
        for (int i = 0; i < logN - 3; i++)
          if (logA[i] != BASE || logD[i] != 32'h00E800E8) ok = 1'b0;
        if (logA[logN-3] != BASE || logD[logN-3] != 32'h00700070) ok = 1'b0;
        if (logA[logN-2] != 24'h100 || logD[logN-2] != 32'h00500050) ok = 1'b0;
        if (logA[logN-1] != 24'h55 || logD[logN-1] != 32'h00FF00FF) ok = 1'b0;
      end
      check(ok, "R7 R9 only requests then read-status, clear, reset", 32'(logN), 32'h5);
    end
    afterDone("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule